// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running 64-bit system counter and raises two signals, one after the other, if software stops refreshing it. Each stage lasts one period of a programmable 32-bit offset. The first stage ends with a level alert meant for an interrupt line. If the alert is not answered with a refresh, the second stage ends with a reset request. A 64-bit compare register holds the deadline. Every refresh and every first-stage expiry reloads it with the live counter value plus the offset.

Software reaches the block through two register windows. Each window has its own simple single-cycle bus: a select, a write flag, a 12-bit byte address and 32-bit write data. Read data comes back combinationally in the same cycle. The refresh window carries the refresh register. The control window carries the control/status word, the offset and the compare value. Both windows expose the same two identification words.

There are two resets. A warm reset clears the timer but keeps the second-stage status bit, so that boot code can tell the watchdog caused the restart. A power-on reset clears everything.

Top module: `dual_stage_wdt`

## Requirements
- R1: After power-on reset every register of the control window reads zero, and `stage1_irq` and `reset_req` are low.
- R2: A write of any data to refresh-window address 0x000 loads the compare value with counter plus zero-extended offset and clears both stage flags. A read of that address returns zero and changes nothing. When a refresh and a direct compare write land in the same cycle, the refresh wins.
- R3: The control/status word is at control address 0x000. Bit 0 is the enable and is the only writable bit. Bit 1 is the first-stage flag and bit 2 is the second-stage flag, and both are read-only. Any write to this word is a refresh.
- R4: A write to the offset register at control address 0x008 stores the new offset. It is a refresh, using the new offset, only while the enable is set. While the enable is clear, the compare value is left untouched.
- R5: While enabled and with the first-stage flag clear, a counter strictly greater than the compare value sets the first-stage flag and `stage1_irq` on the next clock edge, and reloads the compare value with counter plus offset. A counter equal to the compare value does nothing.
- R6: While enabled and with the first-stage flag set, a counter strictly greater than the compare value sets the second-stage flag and `reset_req`. Both stay high until a refresh or a reset.
- R7: While the enable is clear, no stage flag is ever set, whatever the counter does.
- R8: The compare value reads and writes as two 32-bit words, low word at control address 0x010 and high word at 0x014. A direct write to either word is not a refresh.
- R9: A warm reset clears the enable, the offset, the compare value, the first-stage flag and `reset_req`, but keeps the second-stage status bit. A power-on reset also clears that bit.
- R10: In both windows, address 0xFCC reads the interface identification word and 0xFD0 reads the device identification word. Any other unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Warm reset, active low, keeps the second-stage status bit |
| sys_count | input | CNT_W | Free-running system counter |
| ref_sel | input | 1 | Refresh window access this cycle |
| ref_wr | input | 1 | Refresh window access is a write |
| ref_addr | input | 12 | Refresh window byte address |
| ref_wdata | input | WORD_W | Refresh window write data (value ignored) |
| ref_rdata | output | WORD_W | Refresh window read data |
| ctl_sel | input | 1 | Control window access this cycle |
| ctl_wr | input | 1 | Control window access is a write |
| ctl_addr | input | 12 | Control window byte address |
| ctl_wdata | input | WORD_W | Control window write data |
| ctl_rdata | output | WORD_W | Control window read data |
| stage1_irq | output | 1 | First-stage alert level |
| reset_req | output | 1 | Second-stage reset request level |

## Verification
Some properties are checked by assertions on every cycle. A refresh always leaves both flags clear on the next cycle. The enable must be set before the first-stage flag can rise. The second-stage flag rises only out of a set first-stage flag. The reset request holds until it is cleared. A first-stage expiry leaves the compare value at the previous counter plus offset. Other behaviours can only be shown by the bench's scenarios. These include the strict greater-than boundary, the enable-dependent refresh on an offset write and the read-only status bits. They also include the split 64-bit compare access, the survival of the second-stage bit across a warm reset and its loss at power-on, and the identification words in both windows.

// File: rtl/dswdt_pkg.sv
package dswdt_pkg;

  localparam int unsigned ADDR_W = 12;

  // refresh window
  localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;
  // control window
  localparam logic [ADDR_W-1:0] A_CSR    = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET = 12'h008;
  localparam logic [ADDR_W-1:0] A_CMP    = 12'h010;
  // shared identification words
  localparam logic [ADDR_W-1:0] A_IFID   = 12'hFCC;
  localparam logic [ADDR_W-1:0] A_DEVID  = 12'hFD0;

  // status word, bit 0 = enable, bit 1 = stage one, bit 2 = stage two
  typedef struct packed {
    logic ws1;
    logic ws0;
    logic en;
  } wd_state_t;

  function automatic logic [31:0] id_read(input logic [ADDR_W-1:0] a,
                                          input logic [31:0] ifid,
                                          input logic [31:0] devid);
    logic [31:0] r;
    r = '0;
    if (a == A_IFID)  r = ifid;
    if (a == A_DEVID) r = devid;
    return r;
  endfunction

endpackage

// File: rtl/dswdt_timer.sv
module dswdt_timer #(
  parameter int CNT_W  = 64,
  parameter int OFF_W  = 32,
  parameter int WORD_W = 32,
  localparam int HALVES = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              kick,
  input  logic              csr_wr,
  input  logic              csr_en_val,
  input  logic              off_wr,
  input  logic [OFF_W-1:0]  off_val,
  input  logic [HALVES-1:0] cmp_wr,
  input  logic [WORD_W-1:0] cmp_val,
  output logic              en,
  output logic              ws0,
  output logic              ws1,
  output logic              req,
  output logic [OFF_W-1:0]  offset,
  output logic [CNT_W-1:0]  cmp
);

  logic             sys_rst_n;
  logic             en_q, ws0_q, ws1_q, req_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cmp_q;
  logic [OFF_W-1:0] off_next;
  logic             refresh;
  logic             expired;
  logic [CNT_W-1:0] reload;

  assign sys_rst_n = por_n & rst_n;
  assign off_next  = off_wr ? off_val : off_q;
  assign refresh   = kick | csr_wr | (off_wr & en_q);
  assign reload    = count + CNT_W'(off_next);
  assign expired   = en_q & (count > cmp_q) & ~refresh;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      req_q <= 1'b0;
      off_q <= '0;
      cmp_q <= '0;
    end else begin
      if (csr_wr) en_q <= csr_en_val;
      if (off_wr) off_q <= off_val;
      for (int h = 0; h < HALVES; h++) begin
        if (cmp_wr[h]) cmp_q[h*WORD_W +: WORD_W] <= cmp_val;
      end
      if (refresh) begin
        cmp_q <= reload;
        ws0_q <= 1'b0;
        req_q <= 1'b0;
      end else if (expired) begin
        if (!ws0_q) begin
          ws0_q <= 1'b1;
          cmp_q <= reload;
        end else begin
          req_q <= 1'b1;
        end
      end
    end
  end

  // second-stage status survives a warm reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  ws1_q <= 1'b0;
    else if (refresh)            ws1_q <= 1'b0;
    else if (expired && ws0_q)   ws1_q <= 1'b1;
  end

  assign en     = en_q;
  assign ws0    = ws0_q;
  assign ws1    = ws1_q;
  assign req    = req_q;
  assign offset = off_q;
  assign cmp    = cmp_q;

  // R2
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    refresh |=> (!ws0_q && !ws1_q && !req_q));

  // R7
  no_fire_disabled_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !en_q |=> !$rose(ws0_q));

  // R5
  stage1_reload_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(ws0_q) |-> (cmp_q == $past(count) + CNT_W'($past(off_q))));

  // R6
  stage2_order_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(ws1_q) |-> $past(ws0_q));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (req_q && !refresh) |=> req_q);

  // R6
  req_needs_stage1_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    req_q |-> ws0_q);

endmodule

// File: rtl/dswdt_ref_win.sv
module dswdt_ref_win #(
  parameter int          WORD_W = 32,
  parameter logic [31:0] IFID   = 32'h0001_5A17,
  parameter logic [31:0] DEVID  = 32'h0000_00D5
) (
  input  logic                         sel,
  input  logic                         wr,
  input  logic [dswdt_pkg::ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic                         kick,
  output logic [WORD_W-1:0]            rdata
);
  import dswdt_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign kick  = sel & wr & (addr == A_KICK);
  assign rdata = (sel & ~wr) ? WORD_W'(id_read(addr, IFID, DEVID)) : '0;

endmodule

// File: rtl/dswdt_ctl_win.sv
module dswdt_ctl_win #(
  parameter int          CNT_W  = 64,
  parameter int          OFF_W  = 32,
  parameter int          WORD_W = 32,
  parameter logic [31:0] IFID   = 32'h0001_5A17,
  parameter logic [31:0] DEVID  = 32'h0000_00D5,
  localparam int HALVES = CNT_W / WORD_W
) (
  input  logic                         sel,
  input  logic                         wr,
  input  logic [dswdt_pkg::ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic                         en,
  input  logic                         ws0,
  input  logic                         ws1,
  input  logic [OFF_W-1:0]             offset,
  input  logic [CNT_W-1:0]             cmp,
  output logic                         csr_wr,
  output logic                         off_wr,
  output logic [HALVES-1:0]            cmp_wr,
  output logic [WORD_W-1:0]            rdata
);
  import dswdt_pkg::*;

  logic      wr_acc, rd_acc;
  wd_state_t st;

  assign wr_acc = sel & wr;
  assign rd_acc = sel & ~wr;
  assign st     = '{ws1: ws1, ws0: ws0, en: en};

  assign csr_wr = wr_acc & (addr == A_CSR);
  assign off_wr = wr_acc & (addr == A_OFFSET);

  for (genvar h = 0; h < HALVES; h++) begin : g_cmp_dec
    assign cmp_wr[h] = wr_acc & (addr == ADDR_W'(int'(A_CMP) + 4*h));
  end

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      rdata = WORD_W'(id_read(addr, IFID, DEVID));
      if (addr == A_CSR)    rdata = WORD_W'(st);
      if (addr == A_OFFSET) rdata = WORD_W'(offset);
      for (int h = 0; h < HALVES; h++) begin
        if (addr == ADDR_W'(int'(A_CMP) + 4*h)) rdata = cmp[h*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt #(
  parameter int          CNT_W  = 64,
  parameter int          OFF_W  = 32,
  parameter int          WORD_W = 32,
  parameter logic [31:0] IFID   = 32'h0001_5A17,
  parameter logic [31:0] DEVID  = 32'h0000_00D5
) (
  input  logic                         clk,
  input  logic                         por_n,
  input  logic                         rst_n,
  input  logic [CNT_W-1:0]             sys_count,
  input  logic                         ref_sel,
  input  logic                         ref_wr,
  input  logic [dswdt_pkg::ADDR_W-1:0] ref_addr,
  input  logic [WORD_W-1:0]            ref_wdata,
  output logic [WORD_W-1:0]            ref_rdata,
  input  logic                         ctl_sel,
  input  logic                         ctl_wr,
  input  logic [dswdt_pkg::ADDR_W-1:0] ctl_addr,
  input  logic [WORD_W-1:0]            ctl_wdata,
  output logic [WORD_W-1:0]            ctl_rdata,
  output logic                         stage1_irq,
  output logic                         reset_req
);
  localparam int HALVES = CNT_W / WORD_W;

  logic              kick, csr_wr, off_wr;
  logic [HALVES-1:0] cmp_wr;
  logic              en, ws0, ws1, req;
  logic [OFF_W-1:0]  offset;
  logic [CNT_W-1:0]  cmp;

  dswdt_ref_win #(.WORD_W(WORD_W), .IFID(IFID), .DEVID(DEVID)) u_ref (
    .sel(ref_sel), .wr(ref_wr), .addr(ref_addr), .wdata(ref_wdata),
    .kick(kick), .rdata(ref_rdata)
  );

  dswdt_ctl_win #(.CNT_W(CNT_W), .OFF_W(OFF_W), .WORD_W(WORD_W),
                  .IFID(IFID), .DEVID(DEVID)) u_ctl (
    .sel(ctl_sel), .wr(ctl_wr), .addr(ctl_addr), .wdata(ctl_wdata),
    .en(en), .ws0(ws0), .ws1(ws1), .offset(offset), .cmp(cmp),
    .csr_wr(csr_wr), .off_wr(off_wr), .cmp_wr(cmp_wr), .rdata(ctl_rdata)
  );

  dswdt_timer #(.CNT_W(CNT_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .count(sys_count),
    .kick(kick), .csr_wr(csr_wr), .csr_en_val(ctl_wdata[0]),
    .off_wr(off_wr), .off_val(ctl_wdata[OFF_W-1:0]),
    .cmp_wr(cmp_wr), .cmp_val(ctl_wdata),
    .en(en), .ws0(ws0), .ws1(ws1), .req(req), .offset(offset), .cmp(cmp)
  );

  assign stage1_irq = ws0;
  assign reset_req  = req;

endmodule

// File: tb/dual_stage_wdt_test.sv
module dual_stage_wdt_test;
  localparam int          CNT_W = 64;
  localparam logic [31:0] IFID  = 32'h0001_5A17;
  localparam logic [31:0] DEVID = 32'h0000_00D5;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        ref_sel = 1'b0, ref_wr = 1'b0;
  logic [11:0] ref_addr = '0;
  logic [31:0] ref_wdata = '0, ref_rdata;
  logic        ctl_sel = 1'b0, ctl_wr = 1'b0;
  logic [11:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic        stage1_irq, reset_req;

  always #5 clk = ~clk;

  dual_stage_wdt #(.CNT_W(CNT_W), .IFID(IFID), .DEVID(DEVID)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sys_count(sys_count),
    .ref_sel(ref_sel), .ref_wr(ref_wr), .ref_addr(ref_addr),
    .ref_wdata(ref_wdata), .ref_rdata(ref_rdata),
    .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stage1_irq(stage1_irq), .reset_req(reset_req)
  );

  typedef struct {
    bit          is_pin;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails  = 0;
  logic  rd_strobe = 1'b0, pin_strobe = 1'b0, rd_ctl = 1'b0;
  bit    done = 1'b0;

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    #2;
    if (rd_strobe || pin_strobe) begin
      logic [31:0] act;
      item_t it;
      act = pin_strobe ? {30'b0, reset_req, stage1_irq}
                       : (rd_ctl ? ctl_rdata : ref_rdata);
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual %h expected none", act);
      end else begin
        it = sb.pop_front();
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [63:0] v);
    @(negedge clk);
    sys_count = v;
  endtask

  task automatic bus_write(input bit ctl, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    if (ctl) begin ctl_sel = 1; ctl_wr = 1; ctl_addr = a; ctl_wdata = d; end
    else     begin ref_sel = 1; ref_wr = 1; ref_addr = a; ref_wdata = d; end
    @(negedge clk);
    ctl_sel = 0; ctl_wr = 0; ref_sel = 0; ref_wr = 0;
  endtask

  task automatic bus_read(input bit ctl, input logic [11:0] a,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    sb.push_back('{is_pin: 1'b0, exp: exp, tag: tag});
    rd_ctl = ctl;
    if (ctl) begin ctl_sel = 1; ctl_wr = 0; ctl_addr = a; end
    else     begin ref_sel = 1; ref_wr = 0; ref_addr = a; end
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0; ctl_sel = 0; ref_sel = 0;
  endtask

  task automatic pins(input logic [1:0] exp, input string tag);
    @(negedge clk);
    sb.push_back('{is_pin: 1'b1, exp: {30'b0, exp}, tag: tag});
    pin_strobe = 1;
    @(negedge clk);
    pin_strobe = 0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    idle(3);
    por_n = 1; rst_n = 1;

    // R1 reset state
    pins(2'b00, "R1 pins after reset");
    bus_read(1, 12'h000, 32'd0, "R1 status");
    bus_read(1, 12'h008, 32'd0, "R1 offset");
    bus_read(1, 12'h010, 32'd0, "R1 compare lo");
    bus_read(1, 12'h014, 32'd0, "R1 compare hi");
    // R10 identification
    bus_read(1, 12'hFCC, IFID,  "R10 ctl iface id");
    bus_read(0, 12'hFCC, IFID,  "R10 ref iface id");
    bus_read(1, 12'hFD0, DEVID, "R10 ctl dev id");
    bus_read(0, 12'hFD0, DEVID, "R10 ref dev id");
    bus_read(1, 12'h0F0, 32'd0, "R10 unmapped");

    // R4 offset write while disabled does not refresh
    set_count(64'd1000);
    bus_write(1, 12'h008, 32'd100);
    bus_read(1, 12'h010, 32'd0,   "R4 no refresh when disabled");
    bus_read(1, 12'h008, 32'd100, "R4 offset stored");
    // R3 enable write refreshes
    bus_write(1, 12'h000, 32'd1);
    bus_read(1, 12'h000, 32'd1,    "R3 enable set");
    bus_read(1, 12'h010, 32'd1100, "R3 enable refreshes compare");

    // R5 strict compare, then first stage
    set_count(64'd1100);
    idle(3);
    pins(2'b00, "R5 equal count does not fire");
    set_count(64'd1101);
    bus_read(1, 12'h000, 32'd3,    "R5 stage one flag");
    bus_read(1, 12'h010, 32'd1201, "R5 compare reloaded");
    pins(2'b01, "R5 irq high");
    // R2 read of refresh register has no effect
    bus_read(0, 12'h000, 32'd0, "R2 refresh reg reads zero");
    bus_read(1, 12'h000, 32'd3, "R2 read does not refresh");

    // R2 refresh by write
    set_count(64'd1150);
    bus_write(0, 12'h000, 32'hDEAD_BEEF);
    bus_read(1, 12'h000, 32'd1,    "R2 refresh clears stage one");
    bus_read(1, 12'h010, 32'd1250, "R2 refresh reloads compare");
    pins(2'b00, "R2 irq low after refresh");

    // R6 second stage
    set_count(64'd1251);
    bus_read(1, 12'h000, 32'd3, "R6 stage one before stage two");
    set_count(64'd1351);
    pins(2'b01, "R6 equal count holds off stage two");
    set_count(64'd1352);
    bus_read(1, 12'h000, 32'd7, "R6 stage two flag");
    pins(2'b11, "R6 reset request high");
    set_count(64'd5000);
    idle(4);
    pins(2'b11, "R6 reset request held");

    // R9 warm reset keeps stage two status
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
    bus_read(1, 12'h000, 32'd4, "R9 warm reset keeps stage two bit");
    pins(2'b00, "R9 warm reset drops pins");
    bus_read(1, 12'h008, 32'd0, "R9 warm reset clears offset");

    // R3 status write refreshes, status bits read-only
    bus_write(1, 12'h000, 32'd0);
    bus_read(1, 12'h000, 32'd0, "R3 status write clears stage two");
    bus_write(1, 12'h000, 32'hFFFF_FFFE);
    bus_read(1, 12'h000, 32'd0, "R3 status bits not writable");

    // R7 disabled never fires
    set_count(64'd9000);
    idle(3);
    pins(2'b00, "R7 disabled no alert");
    bus_read(1, 12'h000, 32'd0, "R7 disabled no flag");

    // R4 offset write while enabled refreshes with new offset
    bus_write(1, 12'h008, 32'd50);
    set_count(64'd6000);
    bus_write(1, 12'h000, 32'd1);
    bus_read(1, 12'h010, 32'd6050, "R4 enable reload with offset");
    set_count(64'd6040);
    bus_write(1, 12'h008, 32'd20);
    bus_read(1, 12'h010, 32'd6060, "R4 offset write refreshes when enabled");
    set_count(64'd6060);
    idle(2);
    bus_read(1, 12'h000, 32'd1, "R5 equal count no flag");
    set_count(64'd6061);
    bus_read(1, 12'h000, 32'd3, "R5 fires past compare");

    // R8 split compare access
    bus_write(0, 12'h000, 32'd0);
    bus_read(1, 12'h000, 32'd1, "R2 refresh in stage one");
    bus_write(1, 12'h014, 32'd1);
    bus_read(1, 12'h014, 32'd1,    "R8 compare hi written");
    bus_read(1, 12'h010, 32'd6081, "R8 hi write keeps lo, no refresh");
    set_count(64'h0000_0000_FFFF_FFFF);
    idle(2);
    bus_read(1, 12'h000, 32'd1, "R8 high word holds deadline");
    set_count(64'd6500);
    bus_write(1, 12'h010, 32'd7000);
    bus_write(1, 12'h014, 32'd0);
    bus_read(1, 12'h010, 32'd7000, "R8 compare lo written");
    bus_read(1, 12'h000, 32'd1,    "R8 direct write no refresh");
    set_count(64'd7001);
    bus_read(1, 12'h000, 32'd3,    "R8 written compare used");
    bus_read(1, 12'h010, 32'd7021, "R5 reload after direct compare");

    // R9 power-on reset clears stage two
    set_count(64'd7022);
    bus_read(1, 12'h000, 32'd7, "R6 second expiry");
    pins(2'b11, "R6 pins both high");
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    bus_read(1, 12'h000, 32'd0, "R9 power-on clears stage two bit");
    pins(2'b00, "R9 power-on pins low");
    bus_read(1, 12'h008, 32'd0, "R9 power-on clears offset");

    idle(2);
    finish_up();
  end

endmodule